// File: doc/BRIEF.md
# Dual-Port RAM with Same-Word Contention Arbitration

This block is a memory with two independent access ports, left and right. Each port has its own address, write data, chip enable, write select and output enable, and each can read or write the shared array in any clock cycle. The array is `2**ADDR_W` words of `DATA_W` bits. The full-size configuration is `ADDR_W = 13` and `DATA_W = 9`, which gives 8192 words of 9 bits. The default uses a smaller depth so that elaboration stays light. A run-time byte mode narrows the word to its low 8 bits.

A collision happens when both ports select the same word and at least one of them writes. In that case a contention unit picks a winner and raises a busy flag toward the loser. The loser's write is suppressed inside the block. A master/slave select sets where the busy decision comes from:
- **Master:** the local contention unit drives the busy outputs.
- **Slave:** the busy outputs stay low, the local unit is bypassed, and externally supplied busy inputs gate the writes.

With this select, several devices placed side by side to form a wider word can all obey one decision made by the master device.

The model is synchronous. Writes commit at the rising clock edge. Read data and its valid flag appear one cycle after the request. Busy is a combinational function of the current requests and of one cycle of address-ownership history.

Top module: `dual_port_ram_arb`

## Requirements
- R1: A word written through either port at edge N is returned by a read of that address from either port. The read is issued at edge N+1 or later, and its data is valid one cycle after the read request.
- R2: The read-valid output of a port is 1 exactly one cycle after a cycle in which that port had chip enable = 1, output enable = 1 and write select = 0. Otherwise the read-valid output is 0 and the read data is all zeros.
- R3: Two reads of the same address in the same cycle both return the stored word, and neither busy output rises.
- R4: In master mode, when both ports newly select the same word in the same cycle and at least one writes, right busy = 1 and left busy = 0.
- R5: In master mode, a port that selected the same address with chip enable = 1 in the previous cycle, and still selects it, keeps priority over a port that newly arrives at that address. The newcomer gets busy = 1.
- R6: A write from a port whose effective busy is 1 leaves the array unchanged. The winning port's access proceeds normally.
- R7: Simultaneous accesses to different addresses, including two writes, both take effect, and neither busy output rises.
- R8: A port with chip enable = 0 writes nothing, gets no read-valid, and causes no busy on either port.
- R9: In slave mode (master select = 0), both busy outputs are 0 and the local contention decision is ignored. A busy input of 1 blocks that port's write.
- R10: In master mode, the busy inputs have no effect: a write with its busy input at 1 still lands when there is no local contention.
- R11: With byte mode = 1, bit 8 of a written word is stored as 0, and bit 8 of read data is returned as 0 whatever the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| master_i | input | 1 | 1 = local contention decision drives busy; 0 = busy taken from inputs |
| byte_mode_i | input | 1 | 1 = word narrowed to 8 bits |
| l_ce_i | input | 1 | Left chip enable |
| l_we_i | input | 1 | Left write select (1 = write) |
| l_oe_i | input | 1 | Left output enable |
| l_addr_i | input | ADDR_W | Left address |
| l_wdata_i | input | DATA_W | Left write data |
| l_busy_i | input | 1 | Left busy from the master device (slave mode) |
| l_rdata_o | output | DATA_W | Left read data |
| l_rvalid_o | output | 1 | Left read data valid |
| l_busy_o | output | 1 | Left busy (master mode) |
| r_ce_i | input | 1 | Right chip enable |
| r_we_i | input | 1 | Right write select (1 = write) |
| r_oe_i | input | 1 | Right output enable |
| r_addr_i | input | ADDR_W | Right address |
| r_wdata_i | input | DATA_W | Right write data |
| r_busy_i | input | 1 | Right busy from the master device (slave mode) |
| r_rdata_o | output | DATA_W | Right read data |
| r_rvalid_o | output | 1 | Right read data valid |
| r_busy_o | output | 1 | Right busy (master mode) |

## Verification
The bench targets the ownership rule by letting the right port sit on a word for one cycle before the left port writes there. A design that simply favoured the left port would raise the wrong busy flag and corrupt the word. Read/read collisions check that a design raising busy on any address match is caught. Checks on a disabled port writing, and on byte mode masking bit 8, catch designs that ignore the enable or the narrow mode. In slave mode the bench forces a busy input while the local unit would see no contention, and checks that the write is dropped. It also runs the reverse case in master mode, exposing a design that confuses the two busy sources.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_LEFT  = 2'd1,
    WIN_RIGHT = 2'd2
  } win_e;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              r_ce_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  output logic              l_busy_o,
  output logic              r_busy_o
);
  logic              l_ce_q, r_ce_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  logic              l_held, r_held, clash;
  win_e              win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_ce_q   <= 1'b0;
      r_ce_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      l_ce_q   <= l_ce_i;
      r_ce_q   <= r_ce_i;
      l_addr_q <= l_addr_i;
      r_addr_q <= r_addr_i;
    end
  end

  // ownership: same port sat on the same word last cycle
  assign l_held = l_ce_q && (l_addr_q == l_addr_i);
  assign r_held = r_ce_q && (r_addr_q == r_addr_i);
  assign clash  = l_ce_i && r_ce_i && (l_addr_i == r_addr_i) && (l_we_i || r_we_i);

  always_comb begin
    win = WIN_NONE;
    if (clash) begin
      if (r_held && !l_held) win = WIN_RIGHT;
      else                   win = WIN_LEFT;
    end
  end

  assign l_busy_o = (win == WIN_RIGHT);
  assign r_busy_o = (win == WIN_LEFT);

  assert_busy_one_side_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({l_busy_o, r_busy_o}));
  assert_no_busy_on_reads_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_we_i && !r_we_i) |-> (!l_busy_o && !r_busy_o));
  assert_idle_port_no_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_ce_i || !r_ce_i) |-> (!l_busy_o && !r_busy_o));
endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              l_wr_i,
  input  logic              l_rd_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_q_o,
  input  logic              r_wr_i,
  input  logic              r_rd_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_q_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // left write issued last so it takes the word when both write unguarded
  always_ff @(posedge clk_i) begin
    if (r_wr_i) mem[r_addr_i] <= r_wdata_i;
    if (l_wr_i) mem[l_addr_i] <= l_wdata_i;
  end

  // read-first: returns contents before this edge's write
  always_ff @(posedge clk_i) begin
    if (l_rd_i) l_q_o <= mem[l_addr_i];
    if (r_rd_i) r_q_o <= mem[r_addr_i];
  end
endmodule

// File: rtl/dpr_port.sv
module dpr_port #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic              busy_i,
  input  logic              byte_mode_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] q_i,
  output logic              wr_o,
  output logic              rd_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int NARROW_W = (DATA_W > 8) ? 8 : DATA_W;

  logic [DATA_W-1:0] mask;
  logic              narrow_q;
  logic [DATA_W-1:0] rmask;

  generate
    if (DATA_W > NARROW_W) begin : g_wide
      assign mask  = byte_mode_i ? DATA_W'((1 << NARROW_W) - 1) : '1;
      assign rmask = narrow_q    ? DATA_W'((1 << NARROW_W) - 1) : '1;
    end else begin : g_narrow
      assign mask  = '1;
      assign rmask = '1;
    end
  endgenerate

  assign wr_o    = ce_i && we_i && !busy_i;
  assign rd_o    = ce_i && !we_i;
  assign wdata_o = wdata_i & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      narrow_q <= 1'b0;
    end else begin
      rvalid_o <= ce_i && oe_i && !we_i;
      narrow_q <= byte_mode_i;
    end
  end

  assign rdata_o = rvalid_o ? (q_i & rmask) : '0;

  assert_valid_follows_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(ce_i && oe_i && !we_i));
endmodule

// File: rtl/dual_port_ram_arb.sv
module dual_port_ram_arb #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              byte_mode_i,
  input  logic              l_ce_i,
  input  logic              l_we_i,
  input  logic              l_oe_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_busy_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_rvalid_o,
  output logic              l_busy_o,
  input  logic              r_ce_i,
  input  logic              r_we_i,
  input  logic              r_oe_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              r_busy_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_rvalid_o,
  output logic              r_busy_o
);
  logic              arb_l_busy, arb_r_busy;
  logic              l_busy_eff, r_busy_eff;
  logic              l_wr, l_rd, r_wr, r_rd;
  logic [DATA_W-1:0] l_wd, r_wd, l_q, r_q;

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk_i, .rst_ni,
    .l_ce_i, .l_we_i, .l_addr_i,
    .r_ce_i, .r_we_i, .r_addr_i,
    .l_busy_o(arb_l_busy), .r_busy_o(arb_r_busy)
  );

  assign l_busy_eff = master_i ? arb_l_busy : l_busy_i;
  assign r_busy_eff = master_i ? arb_r_busy : r_busy_i;
  assign l_busy_o   = master_i && arb_l_busy;
  assign r_busy_o   = master_i && arb_r_busy;

  dpr_port #(.DATA_W(DATA_W)) u_lport (
    .clk_i, .rst_ni, .ce_i(l_ce_i), .we_i(l_we_i), .oe_i(l_oe_i),
    .busy_i(l_busy_eff), .byte_mode_i, .wdata_i(l_wdata_i), .q_i(l_q),
    .wr_o(l_wr), .rd_o(l_rd), .wdata_o(l_wd), .rdata_o(l_rdata_o), .rvalid_o(l_rvalid_o)
  );

  dpr_port #(.DATA_W(DATA_W)) u_rport (
    .clk_i, .rst_ni, .ce_i(r_ce_i), .we_i(r_we_i), .oe_i(r_oe_i),
    .busy_i(r_busy_eff), .byte_mode_i, .wdata_i(r_wdata_i), .q_i(r_q),
    .wr_o(r_wr), .rd_o(r_rd), .wdata_o(r_wd), .rdata_o(r_rdata_o), .rvalid_o(r_rvalid_o)
  );

  dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i,
    .l_wr_i(l_wr), .l_rd_i(l_rd), .l_addr_i, .l_wdata_i(l_wd), .l_q_o(l_q),
    .r_wr_i(r_wr), .r_rd_i(r_rd), .r_addr_i, .r_wdata_i(r_wd), .r_q_o(r_q)
  );

  assert_slave_busy_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (!l_busy_o && !r_busy_o));
  assert_no_write_when_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_busy_o |-> !l_wr);
endmodule

// File: tb/dual_port_ram_arb_bench.sv
`timescale 1ns/1ps
module dual_port_ram_arb_bench;
  localparam int AW = 11;
  localparam int DW = 9;

  logic clk = 1'b0, rst_n = 1'b0, master = 1'b1, byte_mode = 1'b0;
  logic l_ce = 0, l_we = 0, l_oe = 0, l_bi = 0, r_ce = 0, r_we = 0, r_oe = 0, r_bi = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wd = '0, r_wd = '0, l_rd, r_rd;
  logic l_rv, r_rv, l_bo, r_bo;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  dual_port_ram_arb #(.ADDR_W(AW), .DATA_W(DW)) u_dual_port_ram_arb (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .byte_mode_i(byte_mode),
    .l_ce_i(l_ce), .l_we_i(l_we), .l_oe_i(l_oe), .l_addr_i(l_addr), .l_wdata_i(l_wd),
    .l_busy_i(l_bi), .l_rdata_o(l_rd), .l_rvalid_o(l_rv), .l_busy_o(l_bo),
    .r_ce_i(r_ce), .r_we_i(r_we), .r_oe_i(r_oe), .r_addr_i(r_addr), .r_wdata_i(r_wd),
    .r_busy_i(r_bi), .r_rdata_o(r_rd), .r_rvalid_o(r_rv), .r_busy_o(r_bo)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drv_l(input logic ce, we, oe, input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce = ce; l_we = we; l_oe = oe; l_addr = a; l_wd = d;
  endtask

  task automatic drv_r(input logic ce, we, oe, input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce = ce; r_we = we; r_oe = oe; r_addr = a; r_wd = d;
  endtask

  task automatic idle();
    drv_l(0, 0, 0, '0, '0);
    drv_r(0, 0, 0, '0, '0);
  endtask

  task automatic rd_l(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    idle(); drv_l(1, 0, 1, a, '0); step(); idle();
    chk({tag, " left rvalid"}, 16'(l_rv), 16'd1);
    chk({tag, " left rdata"}, 16'(l_rd), 16'(exp));
  endtask

  task automatic t_reset();
    chk("R2 reset l_rvalid", 16'(l_rv), 0);
    chk("R2 reset r_rvalid", 16'(r_rv), 0);
    chk("R8 reset busy", 16'({l_bo, r_bo}), 0);
    chk("R2 reset rdata", 16'(l_rd | r_rd), 0);
  endtask

  task automatic t_basic();
    drv_l(1, 1, 0, 11'd5, 9'h1A5); drv_r(1, 1, 0, 11'd9, 9'h0F3);
    #1 chk("R7 diff-address writes busy", 16'({l_bo, r_bo}), 0);
    step(); idle();
    drv_l(1, 0, 1, 11'd9, '0); drv_r(1, 0, 1, 11'd5, '0);
    step(); idle();
    chk("R1 left reads right's word", 16'(l_rd), 16'h0F3);
    chk("R1 right reads left's word", 16'(r_rd), 16'h1A5);
  endtask

  task automatic t_readread();
    drv_l(1, 0, 1, 11'd5, '0); drv_r(1, 0, 1, 11'd5, '0);
    #1 chk("R3 read/read busy", 16'({l_bo, r_bo}), 0);
    step(); idle();
    chk("R3 left data", 16'(l_rd), 16'h1A5);
    chk("R3 right data", 16'(r_rd), 16'h1A5);
  endtask

  task automatic t_collide_new();
    idle(); step();
    drv_l(1, 1, 0, 11'd20, 9'h111); drv_r(1, 1, 0, 11'd20, 9'h0AA);
    #1 chk("R4 right busy", 16'(r_bo), 1);
    chk("R4 left not busy", 16'(l_bo), 0);
    step(); idle();
    rd_l(11'd20, 9'h111, "R6 winner write kept");
  endtask

  task automatic t_holder();
    drv_l(1, 1, 0, 11'd30, 9'h1C3); step(); idle(); step();
    drv_r(1, 0, 1, 11'd30, '0); step();
    drv_r(1, 0, 1, 11'd30, '0); drv_l(1, 1, 0, 11'd30, 9'h055);
    #1 chk("R5 newcomer left busy", 16'(l_bo), 1);
    chk("R5 holder right not busy", 16'(r_bo), 0);
    step(); idle();
    chk("R5 holder read data", 16'(r_rd), 16'h1C3);
    step();
    rd_l(11'd30, 9'h1C3, "R6 blocked write");
  endtask

  task automatic t_ce_off();
    drv_l(0, 1, 1, 11'd9, 9'h000); drv_r(1, 1, 0, 11'd9, 9'h0C7);
    #1 chk("R8 disabled port busy", 16'({l_bo, r_bo}), 0);
    step(); idle();
    chk("R8 disabled port rvalid", 16'(l_rv), 0);
    rd_l(11'd9, 9'h0C7, "R8 disabled port wrote nothing");
  endtask

  task automatic t_oe_off();
    drv_l(1, 0, 0, 11'd9, '0); drv_r(1, 1, 1, 11'd50, 9'h012);
    step(); idle();
    chk("R2 oe low rvalid", 16'(l_rv), 0);
    chk("R2 oe low rdata", 16'(l_rd), 0);
    chk("R2 write rvalid", 16'(r_rv), 0);
  endtask

  task automatic t_master_ignores();
    master = 1; l_bi = 1;
    drv_l(1, 1, 0, 11'd40, 9'h0E1);
    #1 chk("R10 busy input not echoed", 16'(l_bo), 0);
    step(); idle();
    rd_l(11'd40, 9'h0E1, "R10 write with busy input");
    l_bi = 0;
  endtask

  task automatic t_slave();
    drv_l(1, 1, 0, 11'd41, 9'h033); step(); idle();
    master = 0; l_bi = 1;
    drv_l(1, 1, 0, 11'd41, 9'h1EE);
    #1 chk("R9 slave busy out low", 16'(l_bo), 0);
    step(); idle(); l_bi = 0;
    drv_l(1, 1, 0, 11'd42, 9'h0AB); drv_r(1, 0, 1, 11'd42, '0);
    #1 chk("R9 slave ignores local clash", 16'({l_bo, r_bo}), 0);
    step(); idle();
    rd_l(11'd41, 9'h033, "R9 busy input blocks write");
    rd_l(11'd42, 9'h0AB, "R9 unblocked slave write");
    master = 1;
  endtask

  task automatic t_byte();
    byte_mode = 1;
    drv_l(1, 1, 0, 11'd60, 9'h1FF); step(); idle();
    rd_l(11'd60, 9'h0FF, "R11 byte write/read");
    rd_l(11'd20, 9'h011, "R11 byte read masks bit 8");
    byte_mode = 0;
    rd_l(11'd60, 9'h0FF, "R11 bit 8 stored as zero");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_readread();
    t_collide_new();
    t_holder();
    t_ce_off();
    t_oe_off();
    t_master_ignores();
    t_slave();
    t_byte();
    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule